// File: doc/BRIEF.md
# PCI Shared Interrupt Line Router

This block steers eight shared PCI interrupt lines, numbered 0 to 7, onto two sets of interrupt-controller inputs at the same time. On the legacy side there are sixteen lines. Each shared line carries a programmable route byte, and a legacy line is driven high whenever any enabled shared line routed to it is high. On the APIC side, shared line n always drives APIC input 16+n, one-to-one, whatever its route byte says.

A power-management SCI input is registered and merged onto one output line. A small select code picks that line from five choices: legacy 9, 10 or 11, or APIC 20 or 21. A reserved code leaves the current choice in place. Separately, a per-slot table turns a device slot and its interrupt pin (INTA to INTD) into a shared-line number. Software can reprogram the upper slots. Slot 30 is hard-wired onto lines 4 to 7 and reads back as zero.

Register writes update state on the next clock. All interrupt outputs follow combinationally from the registered state and the current input levels.

Top module: `pci_line_router`

## Requirements
- R1: After reset, every route byte reads 8'h80 (disabled), all legacy outputs stay low for any shared-line pattern, the stored SCI level is low and the SCI line is legacy 9.
- R2: Route bytes for lines 0-3 sit at reg_addr 0-3 and those for lines 4-7 at reg_addr 8-11. A write updates the byte on the next clock and reg_rdata returns it. Writes to the other addresses change nothing, and those addresses read 0.
- R3: Legacy output k is the OR of every shared line whose route byte has bit 7 clear and bits [4:0] equal to k. A set bit 7 removes the line from the legacy path.
- R4: A route field (bits [4:0]) of 16 or more routes that shared line to no legacy output.
- R5: apic_irq[n] equals share_lvl[n], ORed with the SCI when the SCI line is 16+n.
- R6: On sci_sel_we, select code 0, 1, 2, 4 or 5 sets the SCI line to 9, 10, 11, 20 or 21 on the next clock. Codes 3, 6 and 7 leave the line unchanged.
- R7: When the stored SCI level is high, exactly one output carries it: the selected line. A line change while SCI is high moves it in a single cycle, with the old line dropping as the new one rises.
- R8: sci_in is registered. The outputs show a change on sci_in one clock after it is sampled, and a sample equal to the stored level changes nothing.
- R9: For slots 0-24 the lookup gives line ((slot + pin) mod 4) + 4. Slots 25-29 and 31 reset to the same values.
- R10: A map_we write to slot 25-29 or 31 stores map_wdata, 3 bits per pin with pin 0 in bits [2:0]. The lookup uses the stored values from the next clock on, and map_rdata returns them.
- R11: Slot 30 maps pin p to line 4+p and cannot be written. map_rdata reads 0 for slot 30 and for slots 0-24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Route byte write strobe |
| reg_addr | input | 4 | Route byte address |
| reg_wdata | input | 8 | Route byte write data |
| reg_rdata | output | 8 | Route byte read data for reg_addr |
| sci_sel_we | input | 1 | SCI select write strobe |
| sci_sel | input | 3 | SCI select code |
| sci_in | input | 1 | SCI request level |
| share_lvl | input | 8 | Shared PCI interrupt line levels |
| leg_irq | output | 16 | Legacy controller input levels |
| apic_irq | output | 8 | APIC input levels 16 to 23 |
| map_we | input | 1 | Slot table write strobe |
| map_slot | input | 5 | Slot table write/read slot |
| map_wdata | input | 12 | Slot table write data, 3 bits per pin |
| map_rdata | output | 12 | Slot table read data |
| lk_slot | input | 5 | Lookup slot |
| lk_pin | input | 2 | Lookup pin (0=INTA .. 3=INTD) |
| lk_line | output | 3 | Shared line number for the lookup |

## Verification
A corrupted route byte appears directly at reg_rdata. It also makes a legacy line fire for the wrong shared inputs, and this is visible in the same cycle as the input pattern, because the level path has no register. A wrong SCI line or level shows up one clock after the select or input sample: either two outputs carry the SCI or none does. A bad slot-table entry changes lk_line in the cycle the slot is presented and is also visible through map_rdata.

// File: rtl/pci_line_router_pkg.sv
package pci_line_router_pkg;

  localparam int unsigned SCI_LW = 5;

  typedef struct packed {
    logic              ok;
    logic [SCI_LW-1:0] line;
  } sci_pick_t;

  // Select code to SCI output line; reserved codes return ok = 0
  function automatic sci_pick_t sci_decode(input logic [2:0] code);
    sci_pick_t r;
    r.ok   = 1'b1;
    r.line = 5'd9;
    case (code)
      3'd0: r.line = 5'd9;
      3'd1: r.line = 5'd10;
      3'd2: r.line = 5'd11;
      3'd4: r.line = 5'd20;
      3'd5: r.line = 5'd21;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/plr_route_regs.sv
module plr_route_regs #(
  parameter int unsigned N_SH     = 8,
  parameter int unsigned AW       = 4,
  parameter int unsigned BW       = 8,
  parameter int unsigned HI_BASE  = 8,
  parameter logic [7:0]  RB_RESET = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata,
  output logic [N_SH*BW-1:0] routes
);
  localparam int unsigned GRP = N_SH / 2;

  logic [BW-1:0] rb_q [N_SH];
  logic [BW-1:0] rb_d [N_SH];
  logic [N_SH-1:0] hit;

  // Address decode: low group at 0.., high group at HI_BASE..
  genvar g;
  generate
    for (g = 0; g < N_SH; g++) begin : g_dec
      if (g < GRP) begin : g_lo
        assign hit[g] = (addr == AW'(g));
      end else begin : g_hi
        assign hit[g] = (addr == AW'(HI_BASE + g - GRP));
      end
    end
  endgenerate

  generate
    for (g = 0; g < N_SH; g++) begin : g_rb
      always_comb begin
        rb_d[g] = rb_q[g];
        if (we && hit[g]) rb_d[g] = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q[g] <= RB_RESET;
        else        rb_q[g] <= rb_d[g];
      end

      assign routes[g*BW +: BW] = rb_q[g];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_SH; i++) begin
      if (hit[i]) rdata = rb_q[i];
    end
  end

endmodule

// File: rtl/plr_slot_map.sv
module plr_slot_map #(
  parameter int unsigned N_SLOT  = 32,
  parameter int unsigned PROG_LO = 25,
  parameter int unsigned FIXED   = 30,
  parameter int unsigned N_PIN   = 4,
  parameter int unsigned LW      = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     map_we,
  input  logic [$clog2(N_SLOT)-1:0] map_slot,
  input  logic [N_PIN*LW-1:0]      map_wdata,
  output logic [N_PIN*LW-1:0]      map_rdata,
  input  logic [$clog2(N_SLOT)-1:0] lk_slot,
  input  logic [$clog2(N_PIN)-1:0] lk_pin,
  output logic [LW-1:0]            lk_line
);
  localparam int unsigned SW  = $clog2(N_SLOT);
  localparam int unsigned WW  = N_PIN * LW;
  localparam int unsigned HALF = 4;

  // Default entry: ((slot + pin) mod 4) + 4
  function automatic logic [LW-1:0] dflt(input int unsigned s, input int unsigned p);
    return LW'(((s + p) % HALF) + HALF);
  endfunction

  function automatic logic [WW-1:0] dflt_word(input int unsigned s);
    logic [WW-1:0] w;
    for (int unsigned p = 0; p < N_PIN; p++) w[p*LW +: LW] = dflt(s, p);
    return w;
  endfunction

  logic [WW-1:0] word_tbl [N_SLOT];
  logic [WW-1:0] read_tbl [N_SLOT];

  genvar s;
  generate
    for (s = 0; s < N_SLOT; s++) begin : g_slot
      if (s == FIXED) begin : g_fixed
        always_comb begin
          for (int unsigned p = 0; p < N_PIN; p++)
            word_tbl[s][p*LW +: LW] = LW'(HALF + p);
        end
        assign read_tbl[s] = '0;
      end else if (s >= PROG_LO) begin : g_prog
        logic [WW-1:0] ent_q;
        logic [WW-1:0] ent_d;
        logic          ent_en;

        assign ent_en = map_we && (map_slot == SW'(s));

        always_comb begin
          ent_d = ent_q;
          if (ent_en) ent_d = map_wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ent_q <= dflt_word(s);
          else        ent_q <= ent_d;
        end

        assign word_tbl[s] = ent_q;
        assign read_tbl[s] = ent_q;
      end else begin : g_const
        assign word_tbl[s] = dflt_word(s);
        assign read_tbl[s] = '0;
      end
    end
  endgenerate

  logic [WW-1:0] lk_word;
  assign lk_word   = word_tbl[lk_slot];
  assign lk_line   = lk_word[lk_pin*LW +: LW];
  assign map_rdata = read_tbl[map_slot];

endmodule

// File: rtl/plr_sci_steer.sv
module plr_sci_steer
  import pci_line_router_pkg::*;
#(
  parameter int unsigned LEG_N     = 16,
  parameter int unsigned APIC_N    = 8,
  parameter int unsigned APIC_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sci_in,
  input  logic              sel_we,
  input  logic [2:0]        sel,
  output logic              sci_lvl,
  output logic [SCI_LW-1:0] sci_line,
  output logic [LEG_N-1:0]  sci_leg,
  output logic [APIC_N-1:0] sci_apic
);
  logic              lvl_q, lvl_d;
  logic [SCI_LW-1:0] line_q, line_d;
  sci_pick_t         pick;

  assign pick = sci_decode(sel);

  always_comb begin
    lvl_d  = lvl_q;
    line_d = line_q;
    if (sci_in != lvl_q) lvl_d = sci_in;
    if (sel_we && pick.ok) line_d = pick.line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      line_q <= 5'd9;
    end else begin
      lvl_q  <= lvl_d;
      line_q <= line_d;
    end
  end

  genvar k;
  generate
    for (k = 0; k < LEG_N; k++) begin : g_leg
      assign sci_leg[k] = lvl_q && (line_q == SCI_LW'(k));
    end
    for (k = 0; k < APIC_N; k++) begin : g_apic
      assign sci_apic[k] = lvl_q && (line_q == SCI_LW'(APIC_BASE + k));
    end
  endgenerate

  assign sci_lvl  = lvl_q;
  assign sci_line = line_q;

endmodule

// File: rtl/plr_level_combine.sv
module plr_level_combine #(
  parameter int unsigned N_SH   = 8,
  parameter int unsigned BW     = 8,
  parameter int unsigned FW     = 5,
  parameter int unsigned DIS_B  = 7,
  parameter int unsigned LEG_N  = 16,
  parameter int unsigned APIC_N = 8
) (
  input  logic [N_SH*BW-1:0] routes,
  input  logic [N_SH-1:0]    share_lvl,
  input  logic [LEG_N-1:0]   sci_leg,
  input  logic [APIC_N-1:0]  sci_apic,
  output logic [LEG_N-1:0]   leg_irq,
  output logic [APIC_N-1:0]  apic_irq
);
  logic [N_SH-1:0] live;
  logic [FW-1:0]   fld [N_SH];

  genvar n, k;
  generate
    for (n = 0; n < N_SH; n++) begin : g_src
      assign live[n] = share_lvl[n] && !routes[n*BW + DIS_B];
      assign fld[n]  = routes[n*BW +: FW];
    end

    for (k = 0; k < LEG_N; k++) begin : g_leg
      logic hit_any;
      always_comb begin
        hit_any = 1'b0;
        for (int i = 0; i < N_SH; i++) begin
          if (live[i] && (fld[i] == FW'(k))) hit_any = 1'b1;
        end
      end
      assign leg_irq[k] = hit_any | sci_leg[k];
    end

    for (k = 0; k < APIC_N; k++) begin : g_apic
      if (k < N_SH) begin : g_pass
        assign apic_irq[k] = share_lvl[k] | sci_apic[k];
      end else begin : g_sci_only
        assign apic_irq[k] = sci_apic[k];
      end
    end
  endgenerate

endmodule

// File: rtl/pci_line_router.sv
module pci_line_router
  import pci_line_router_pkg::*;
#(
  parameter int unsigned N_SH      = 8,
  parameter int unsigned LEG_N     = 16,
  parameter int unsigned APIC_BASE = 16,
  parameter int unsigned N_SLOT    = 32,
  parameter int unsigned PROG_LO   = 25,
  parameter int unsigned FIXED     = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        sci_sel_we,
  input  logic [2:0]  sci_sel,
  input  logic        sci_in,
  input  logic [7:0]  share_lvl,
  output logic [15:0] leg_irq,
  output logic [7:0]  apic_irq,
  input  logic        map_we,
  input  logic [4:0]  map_slot,
  input  logic [11:0] map_wdata,
  output logic [11:0] map_rdata,
  input  logic [4:0]  lk_slot,
  input  logic [1:0]  lk_pin,
  output logic [2:0]  lk_line
);
  localparam int unsigned BW     = 8;
  localparam int unsigned APIC_N = N_SH;

  logic [N_SH*BW-1:0] routes;
  logic               sci_lvl_q;
  logic [SCI_LW-1:0]  sci_line_q;
  logic [LEG_N-1:0]   sci_leg_vec;
  logic [APIC_N-1:0]  sci_apic_vec;

  plr_route_regs #(.N_SH(N_SH), .AW(4), .BW(BW), .HI_BASE(8), .RB_RESET(8'h80)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .routes(routes)
  );

  plr_sci_steer #(.LEG_N(LEG_N), .APIC_N(APIC_N), .APIC_BASE(APIC_BASE)) u_sci (
    .clk(clk), .rst_n(rst_n), .sci_in(sci_in), .sel_we(sci_sel_we), .sel(sci_sel),
    .sci_lvl(sci_lvl_q), .sci_line(sci_line_q),
    .sci_leg(sci_leg_vec), .sci_apic(sci_apic_vec)
  );

  plr_level_combine #(.N_SH(N_SH), .BW(BW), .FW(5), .DIS_B(7),
                      .LEG_N(LEG_N), .APIC_N(APIC_N)) u_comb (
    .routes(routes), .share_lvl(share_lvl), .sci_leg(sci_leg_vec),
    .sci_apic(sci_apic_vec), .leg_irq(leg_irq), .apic_irq(apic_irq)
  );

  plr_slot_map #(.N_SLOT(N_SLOT), .PROG_LO(PROG_LO), .FIXED(FIXED),
                 .N_PIN(4), .LW(3)) u_map (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_slot(map_slot),
    .map_wdata(map_wdata), .map_rdata(map_rdata),
    .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_line(lk_line)
  );

endmodule

// File: rtl/pci_line_router_chk.sv
module pci_line_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sci_sel_we,
  input logic [2:0]  sci_sel,
  input logic        sci_in,
  input logic [7:0]  share_lvl,
  input logic [15:0] leg_irq,
  input logic [7:0]  apic_irq,
  input logic [4:0]  map_slot,
  input logic [11:0] map_rdata,
  input logic [4:0]  lk_slot,
  input logic [1:0]  lk_pin,
  input logic [2:0]  lk_line,
  input logic        sci_lvl,
  input logic [4:0]  sci_line,
  input logic [15:0] sci_leg,
  input logic [7:0]  sci_apic
);
  AST_NO_SOURCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (share_lvl == 8'h00 && !sci_lvl) |-> (leg_irq == 16'h0 && apic_irq == 8'h0)); // R3

  AST_APIC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ((share_lvl & ~apic_irq) == 8'h00)); // R5

  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_sel_we && (sci_sel == 3'd3 || sci_sel >= 3'd6)) |=> $stable(sci_line)); // R6

  AST_SCI_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sci_leg, sci_apic}) == (sci_lvl ? 1 : 0)); // R7

  AST_SCI_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sci_lvl == $past(sci_in))); // R8

  AST_FIXED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_slot == 5'd30) |-> (lk_line == {1'b1, lk_pin})); // R11

  AST_FIXED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (map_slot == 5'd30) |-> (map_rdata == 12'h000)); // R11
endmodule

bind pci_line_router pci_line_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sci_sel_we(sci_sel_we), .sci_sel(sci_sel),
  .sci_in(sci_in), .share_lvl(share_lvl), .leg_irq(leg_irq), .apic_irq(apic_irq),
  .map_slot(map_slot), .map_rdata(map_rdata), .lk_slot(lk_slot), .lk_pin(lk_pin),
  .lk_line(lk_line), .sci_lvl(sci_lvl_q), .sci_line(sci_line_q),
  .sci_leg(sci_leg_vec), .sci_apic(sci_apic_vec)
);

// File: tb/pci_line_router_bench.sv
module pci_line_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        sci_sel_we = 1'b0;
  logic [2:0]  sci_sel = '0;
  logic        sci_in = 1'b0;
  logic [7:0]  share_lvl = '0;
  logic [15:0] leg_irq;
  logic [7:0]  apic_irq;
  logic        map_we = 1'b0;
  logic [4:0]  map_slot = '0;
  logic [11:0] map_wdata = '0;
  logic [11:0] map_rdata;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pci_line_router u_pci_line_router (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_route(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wr_sel(input logic [2:0] c);
    @(negedge clk); sci_sel_we = 1'b1; sci_sel = c;
    @(negedge clk); sci_sel_we = 1'b0;
  endtask

  // {share_lvl, expected legacy} with A->5 B->5 C->9 D off E->15 F->20 G->0 H->9
  localparam logic [23:0] VEC [11] = '{
    {8'h01, 16'h0020}, {8'h02, 16'h0020}, {8'h04, 16'h0200},
    {8'h08, 16'h0000}, {8'h10, 16'h8000}, {8'h20, 16'h0000},
    {8'h40, 16'h0001}, {8'h80, 16'h0200}, {8'h84, 16'h0200},
    {8'hFF, 16'h8221}, {8'h00, 16'h0000}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a); #1;
      if (a < 4 || (a >= 8 && a < 12)) chk(reg_rdata == 8'h80, "R1 route reset", reg_rdata, 8'h80);
      else chk(reg_rdata == 8'h00, "R2 unused addr reads 0", reg_rdata, 0);
    end
    share_lvl = 8'hFF; #1;
    chk(leg_irq == 16'h0, "R1 legacy quiet at reset", leg_irq, 0);
    chk(apic_irq == 8'hFF, "R5 apic passthrough", apic_irq, 8'hFF);
    share_lvl = 8'h00;

    // R2 program routes; also write to an unused address
    wr_route(4'd0, 8'h05); wr_route(4'd1, 8'h05); wr_route(4'd2, 8'h09);
    wr_route(4'd3, 8'h85); wr_route(4'd8, 8'h0F); wr_route(4'd9, 8'h14);
    wr_route(4'd10, 8'h00); wr_route(4'd11, 8'h09); wr_route(4'd5, 8'h07);
    reg_addr = 4'd9; #1;
    chk(reg_rdata == 8'h14, "R2 readback high group", reg_rdata, 8'h14);
    reg_addr = 4'd3; #1;
    chk(reg_rdata == 8'h85, "R2 readback low group", reg_rdata, 8'h85);
    reg_addr = 4'd5; #1;
    chk(reg_rdata == 8'h00, "R2 unused write ignored", reg_rdata, 0);

    // R3 R4 R5 table walk
    foreach (VEC[i]) begin
      share_lvl = VEC[i][23:16]; #1;
      chk(leg_irq == VEC[i][15:0], "R3 R4 legacy OR", leg_irq, VEC[i][15:0]);
      chk(apic_irq == VEC[i][23:16], "R5 apic level", apic_irq, VEC[i][23:16]);
      @(negedge clk);
    end

    // R8 SCI registered, R7 on line 9
    share_lvl = 8'h00;
    sci_in = 1'b1; #1;
    chk(leg_irq == 16'h0, "R8 sci not yet visible", leg_irq, 0);
    @(negedge clk);
    chk(leg_irq == 16'h0200, "R8 R7 sci on legacy 9", leg_irq, 16'h0200);
    @(negedge clk);
    chk(leg_irq == 16'h0200, "R8 equal level no change", leg_irq, 16'h0200);

    // R6 R7 move to 21 while asserted
    @(negedge clk); sci_sel_we = 1'b1; sci_sel = 3'd5; #1;
    chk(leg_irq == 16'h0200, "R6 select not before clock", leg_irq, 16'h0200);
    @(negedge clk); sci_sel_we = 1'b0;
    chk(leg_irq == 16'h0 && apic_irq == 8'h20, "R7 moved to apic 21",
        {leg_irq, apic_irq}, 24'h000020);
    wr_sel(3'd7);
    chk(apic_irq == 8'h20 && leg_irq == 16'h0, "R6 reserved 7 keeps line",
        {leg_irq, apic_irq}, 24'h000020);
    wr_sel(3'd3);
    chk(apic_irq == 8'h20, "R6 reserved 3 keeps line", apic_irq, 8'h20);
    share_lvl = 8'h20; #1;
    chk(apic_irq == 8'h20, "R5 apic OR with sci", apic_irq, 8'h20);
    share_lvl = 8'h00;
    wr_sel(3'd1);
    chk(leg_irq == 16'h0400 && apic_irq == 8'h0, "R6 R7 legacy 10",
        {leg_irq, apic_irq}, 24'h040000);
    wr_sel(3'd4);
    chk(apic_irq == 8'h10, "R6 apic 20", apic_irq, 8'h10);
    wr_sel(3'd2);
    chk(leg_irq == 16'h0800, "R6 legacy 11", leg_irq, 16'h0800);
    wr_sel(3'd6);
    chk(leg_irq == 16'h0800, "R6 reserved 6 keeps line", leg_irq, 16'h0800);
    sci_in = 1'b0;
    @(negedge clk);
    chk(leg_irq == 16'h0 && apic_irq == 8'h0, "R8 sci released",
        {leg_irq, apic_irq}, 0);

    // R9 default slot map
    lk_slot = 5'd0; lk_pin = 2'd0; #1;
    chk(lk_line == 3'd4, "R9 slot0 pin0", lk_line, 4);
    lk_slot = 5'd3; lk_pin = 2'd2; #1;
    chk(lk_line == 3'd5, "R9 slot3 pin2", lk_line, 5);
    lk_slot = 5'd25; lk_pin = 2'd0; #1;
    chk(lk_line == 3'd5, "R9 slot25 reset", lk_line, 5);
    map_slot = 5'd25; #1;
    chk(map_rdata == 12'h9F5, "R9 slot25 reset word", map_rdata, 12'h9F5);

    // R11 fixed slot
    lk_slot = 5'd30; lk_pin = 2'd1; #1;
    chk(lk_line == 3'd5, "R11 slot30 pin1", lk_line, 5);

    // R10 write slot 25, R11 writes to 30 and 10 ignored
    @(negedge clk); map_we = 1'b1; map_slot = 5'd25; map_wdata = 12'h053;
    @(negedge clk); map_slot = 5'd30; map_wdata = 12'hFFF;
    @(negedge clk); map_slot = 5'd10; map_wdata = 12'hFFF;
    @(negedge clk); map_we = 1'b0;
    map_slot = 5'd25; lk_slot = 5'd25; lk_pin = 2'd0; #1;
    chk(map_rdata == 12'h053, "R10 slot25 readback", map_rdata, 12'h053);
    chk(lk_line == 3'd3, "R10 slot25 pin0", lk_line, 3);
    lk_pin = 2'd3; #1;
    chk(lk_line == 3'd0, "R10 slot25 pin3", lk_line, 0);
    map_slot = 5'd30; lk_slot = 5'd30; lk_pin = 2'd3; #1;
    chk(map_rdata == 12'h000, "R11 slot30 reads 0", map_rdata, 0);
    chk(lk_line == 3'd7, "R11 slot30 write ignored", lk_line, 7);
    map_slot = 5'd10; lk_slot = 5'd10; lk_pin = 2'd1; #1;
    chk(map_rdata == 12'h000, "R11 slot10 reads 0", map_rdata, 0);
    chk(lk_line == 3'd7, "R9 slot10 write ignored", lk_line, 7);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule